// File: doc/BRIEF.md
# PCI Delayed Read Target Controller

This block is the read path of a PCI target that fronts a slower internal bus. When a PCI master reads, the block captures the address and command, answers with retry, and fetches a burst over an internal-bus master port into a sixteen-word buffer. Every read that arrives during the fetch is told to retry. Once the data is buffered, only a read with the same word address and the same command is served. Any other read is told to retry.

The PCI side is reduced to a one-cycle request (valid, address, command, requested word count). Data beats come back on a data strobe, and each transfer ends with a termination code. The prefetch length depends on the command and the cache-line size, and it is cut short so that it never crosses a 64-byte boundary. Buffered data that is not collected within a programmable number of cycles is dropped. An internal bus error makes the pending read end in target abort. Sticky flags and maskable interrupts report both events.

Top module: `pci_delayed_read`

## Requirements
- R1: After reset, `rsp_valid`, `dat_valid` and `ib_req` are 0, all three status flags are 0, and the block is idle.
- R2: In the idle state, a read request (command 4'h6, 4'hE or 4'hC) with `dr_bypass`=0 is answered one cycle later with `rsp_valid`=1 and `rsp_kind`=0 (retry). In that same cycle `ib_req` pulses for one cycle, `ib_addr` carries the request address with bits 1:0 cleared, and `ib_len` carries the prefetch word count.
- R3: While the internal fetch is running, every read request is answered with retry and no new `ib_req` is issued.
- R4: With a valid cache-line size, the prefetch length is 1 word for 4'h6, the cache-line size for 4'hE, and 16 words for 4'hC. A cache-line size counts as valid when it is a nonzero power of two of at most 16.
- R5: With an invalid cache-line size, the prefetch length is 16 words for every read command.
- R6: Once the data is buffered, a read whose address bits 31:2 or whose command differs from the captured pair is answered with retry. A matching read is served: from the next cycle on, `dat_valid` is 1 for one cycle per word, and the words appear in fetch order.
- R7: The number of words served is the smaller of the requested count (0 counts as 1) and the prefetched count. The cycle after the last word carries `rsp_valid`=1 with `rsp_kind`=2 (disconnect) if more words were requested than were prefetched, and `rsp_kind`=1 (done) otherwise. The block is then idle again.
- R8: The prefetch length is limited to the words left before the next 64-byte boundary, which is 16 minus address bits 5:2.
- R9: If no matching read arrives, the buffered data is dropped and `sts_discard` is set at the DISCARD_CYCLES-th clock edge after the edge that stored the last word. The block is then idle.
- R10: An `ib_err` during the fetch sets both `sts_ib_err` and `sts_pci_err`. After that, a matching read is answered with `rsp_kind`=3 (target abort) and the block returns to idle, while a non-matching read gets retry.
- R11: `irq_int` is 1 when `sts_discard` is set with `int_mask[0]`=0, or when `sts_ib_err` is set with `int_mask[1]`=0. `irq_pci` is 1 when `sts_pci_err` is set with `pci_mask`=0.
- R12: With `dr_bypass`=1, a read in the idle state gets no response and starts no fetch. Requests with a command that is not a read are never answered.
- R13: A 1 on bit i of `flag_clr` clears status flag i (bit 0 discard, bit 1 internal error, bit 2 PCI error). If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dr_bypass | input | 1 | 1 disables the delayed-read path |
| cls | input | 8 | Cache-line size in words |
| req_valid | input | 1 | One-cycle PCI request strobe |
| req_addr | input | 32 | Request byte address |
| req_cmd | input | 4 | Request command |
| req_words | input | 5 | Words the master wants |
| rsp_valid | output | 1 | Termination response strobe |
| rsp_kind | output | 2 | 0 retry, 1 done, 2 disconnect, 3 target abort |
| dat_valid | output | 1 | Data beat strobe |
| dat_data | output | 32 | Data beat |
| ib_req | output | 1 | Internal read start pulse |
| ib_addr | output | 32 | Internal read word-aligned address |
| ib_len | output | 5 | Internal read word count |
| ib_rvalid | input | 1 | Internal read data strobe |
| ib_rdata | input | 32 | Internal read data |
| ib_err | input | 1 | Internal bus error |
| int_mask | input | 2 | Internal interrupt masks (bit 0 discard, bit 1 error) |
| pci_mask | input | 1 | PCI interrupt mask |
| flag_clr | input | 3 | Status flag clear strobes |
| sts_discard | output | 1 | Data dropped on timeout |
| sts_ib_err | output | 1 | Internal-side bus error |
| sts_pci_err | output | 1 | PCI-side bus error |
| irq_int | output | 1 | Internal-side interrupt |
| irq_pci | output | 1 | PCI-side interrupt |

## Verification
The bench runs the prefetch length through each read command with valid and invalid cache-line sizes and with start addresses close to the 64-byte boundary. A wrong length shows up both on `ib_len` and as a wrong count of beats before the termination. Each served read is preceded by a read with the same address and a different command, so a design that compares only the address would hand out data where retry is due. The discard is checked at the last edge before the timeout and at the timeout edge, which catches an off-by-one in the timer. The error path is checked for abort on the matching read, retry on a non-matching one, a retry during the fetch, and masking of the interrupt on each side.

// File: rtl/pci_delayed_read.sv
module pci_delayed_read #(
  parameter int DISCARD_CYCLES = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dr_bypass,
  input  logic [7:0]  cls,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [3:0]  req_cmd,
  input  logic [4:0]  req_words,
  output logic        rsp_valid,
  output logic [1:0]  rsp_kind,
  output logic        dat_valid,
  output logic [31:0] dat_data,
  output logic        ib_req,
  output logic [31:0] ib_addr,
  output logic [4:0]  ib_len,
  input  logic        ib_rvalid,
  input  logic [31:0] ib_rdata,
  input  logic        ib_err,
  input  logic [1:0]  int_mask,
  input  logic        pci_mask,
  input  logic [2:0]  flag_clr,
  output logic        sts_discard,
  output logic        sts_ib_err,
  output logic        sts_pci_err,
  output logic        irq_int,
  output logic        irq_pci
);
  localparam int TW = $clog2(DISCARD_CYCLES + 1);
  localparam logic [TW-1:0] TLAST = TW'(DISCARD_CYCLES - 1);
  localparam logic [3:0] C_MR = 4'h6, C_MRL = 4'hE, C_MRM = 4'hC;
  localparam logic [1:0] K_RETRY = 2'd0, K_DONE = 2'd1, K_DISC = 2'd2, K_ABORT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_READY, S_SERVE, S_ERR} state_t;
  state_t st;

  logic [29:0] cap_addr;
  logic [3:0]  cap_cmd;
  logic [4:0]  len_q, n_q;
  logic [3:0]  cnt, idx;
  logic        disc_q;
  logic [TW-1:0] tmr;
  logic [2:0]  flags;
  logic [31:0] buf_q [16];
  logic        rsp_v;
  logic [1:0]  rsp_k;
  logic        ib_req_q;

  wire is_rd  = req_cmd == C_MR || req_cmd == C_MRL || req_cmd == C_MRM;
  wire rd     = req_valid && is_rd;
  wire hit    = req_addr[31:2] == cap_addr && req_cmd == cap_cmd;
  wire cls_ok = cls != 8'd0 && cls <= 8'd16 && (cls & (cls - 8'd1)) == 8'd0;

  logic [4:0] base_len, to_bnd, new_len, w_eff;
  always_comb begin
    if (!cls_ok || req_cmd == C_MRM) base_len = 5'd16;
    else if (req_cmd == C_MRL)       base_len = cls[4:0];
    else                             base_len = 5'd1;
    to_bnd  = 5'd16 - {1'b0, req_addr[5:2]};
    new_len = base_len < to_bnd ? base_len : to_bnd;
    w_eff   = req_words == 5'd0 ? 5'd1 : req_words;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cap_addr <= '0; cap_cmd <= '0; len_q <= 5'd1; n_q <= 5'd1;
      cnt <= '0; idx <= '0; disc_q <= 1'b0; tmr <= '0;
      flags <= '0; rsp_v <= 1'b0; rsp_k <= K_RETRY; ib_req_q <= 1'b0;
    end else begin
      rsp_v    <= 1'b0;
      ib_req_q <= 1'b0;
      flags    <= flags & ~flag_clr;
      case (st)
        S_IDLE: if (rd && !dr_bypass) begin
          cap_addr <= req_addr[31:2];
          cap_cmd  <= req_cmd;
          len_q    <= new_len;
          cnt      <= '0;
          rsp_v    <= 1'b1; rsp_k <= K_RETRY;
          ib_req_q <= 1'b1;
          st       <= S_FETCH;
        end
        S_FETCH: begin
          if (rd) begin rsp_v <= 1'b1; rsp_k <= K_RETRY; end
          if (ib_err) begin
            flags[1] <= 1'b1;
            flags[2] <= 1'b1;
            st       <= S_ERR;
          end else if (ib_rvalid) begin
            cnt <= cnt + 4'd1;
            if ({1'b0, cnt} == len_q - 5'd1) begin
              tmr <= '0;
              st  <= S_READY;
            end
          end
        end
        S_READY: begin
          if (rd && hit) begin
            idx    <= '0;
            n_q    <= w_eff < len_q ? w_eff : len_q;
            disc_q <= w_eff > len_q;
            st     <= S_SERVE;
          end else begin
            if (rd) begin rsp_v <= 1'b1; rsp_k <= K_RETRY; end
            if (tmr == TLAST) begin
              flags[0] <= 1'b1;
              st       <= S_IDLE;
            end else tmr <= tmr + 1'b1;
          end
        end
        S_SERVE: begin
          if ({1'b0, idx} == n_q - 5'd1) begin
            rsp_v <= 1'b1;
            rsp_k <= disc_q ? K_DISC : K_DONE;
            st    <= S_IDLE;
          end else idx <= idx + 4'd1;
        end
        S_ERR: if (rd) begin
          rsp_v <= 1'b1;
          rsp_k <= hit ? K_ABORT : K_RETRY;
          if (hit) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st == S_FETCH && ib_rvalid && !ib_err) buf_q[cnt] <= ib_rdata;

  assign rsp_valid   = rsp_v;
  assign rsp_kind    = rsp_k;
  assign dat_valid   = st == S_SERVE;
  assign dat_data    = buf_q[idx];
  assign ib_req      = ib_req_q;
  assign ib_addr     = {cap_addr, 2'b00};
  assign ib_len      = len_q;
  assign sts_discard = flags[0];
  assign sts_ib_err  = flags[1];
  assign sts_pci_err = flags[2];
  assign irq_int     = (flags[0] && !int_mask[0]) || (flags[1] && !int_mask[1]);
  assign irq_pci     = flags[2] && !pci_mask;
endmodule

module pci_delayed_read_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rsp_valid,
  input logic [1:0]  rsp_kind,
  input logic        dat_valid,
  input logic        ib_req,
  input logic [31:0] ib_addr,
  input logic [4:0]  ib_len,
  input logic        sts_ib_err,
  input logic        sts_pci_err
);
  AST_FETCH_RETRIED: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> rsp_valid && rsp_kind == 2'd0);  // R2
  AST_NO_BOUNDARY_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req |-> ib_len != 5'd0 && ib_len <= 5'd16 - {1'b0, ib_addr[5:2]});  // R8
  AST_ERR_BOTH_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_ib_err) |-> sts_pci_err);  // R10
  AST_DISC_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == 2'd2 |-> $past(dat_valid));  // R7
  AST_BEAT_NOT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> !rsp_valid);  // R6
endmodule

bind pci_delayed_read pci_delayed_read_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
  .dat_valid(dat_valid), .ib_req(ib_req), .ib_addr(ib_addr), .ib_len(ib_len),
  .sts_ib_err(sts_ib_err), .sts_pci_err(sts_pci_err)
);

// File: tb/test_pci_delayed_read.sv
module test_pci_delayed_read;
  localparam int DISC = 32768;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dr_bypass = 1'b0, req_valid = 1'b0, ib_rvalid = 1'b0, ib_err = 1'b0, pci_mask = 1'b0;
  logic [7:0] cls = 8'd8;
  logic [31:0] req_addr = '0, ib_rdata = '0;
  logic [3:0] req_cmd = '0;
  logic [4:0] req_words = 5'd16;
  logic [1:0] int_mask = '0;
  logic [2:0] flag_clr = '0;
  logic rsp_valid, dat_valid, ib_req, sts_discard, sts_ib_err, sts_pci_err, irq_int, irq_pci;
  logic [1:0] rsp_kind;
  logic [31:0] dat_data, ib_addr;
  logic [4:0] ib_len;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  pci_delayed_read #(.DISCARD_CYCLES(DISC)) i_pci_delayed_read (
    .clk(clk), .rst_n(rst_n), .dr_bypass(dr_bypass), .cls(cls),
    .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd), .req_words(req_words),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .dat_valid(dat_valid), .dat_data(dat_data),
    .ib_req(ib_req), .ib_addr(ib_addr), .ib_len(ib_len),
    .ib_rvalid(ib_rvalid), .ib_rdata(ib_rdata), .ib_err(ib_err),
    .int_mask(int_mask), .pci_mask(pci_mask), .flag_clr(flag_clr),
    .sts_discard(sts_discard), .sts_ib_err(sts_ib_err), .sts_pci_err(sts_pci_err),
    .irq_int(irq_int), .irq_pci(irq_pci));

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input logic [3:0] c, input logic [4:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmd = c; req_words = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic feed(input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      ib_rvalid = 1'b1; ib_rdata = seed + 32'(i);
      @(negedge clk);
    end
    ib_rvalid = 1'b0;
  endtask

  task automatic serve(input int n, input logic [31:0] seed, input logic [1:0] kind, input string r);
    for (int i = 0; i < n; i++) begin
      check(r, {dat_valid, dat_data}, {1'b1, seed + 32'(i)});
      @(negedge clk);
    end
    check(r, {dat_valid, rsp_valid, rsp_kind}, {2'b01, kind});
  endtask

  // cmd, cls, addr, expected prefetch length
  localparam logic [48:0] VEC [8] = '{
    {4'h6, 8'd8,  32'h0000_1000, 5'd1},
    {4'hE, 8'd8,  32'h0000_2000, 5'd8},
    {4'hC, 8'd8,  32'h0000_3000, 5'd16},
    {4'hE, 8'd6,  32'h0000_4000, 5'd16},
    {4'h6, 8'd0,  32'h0000_5000, 5'd16},
    {4'hC, 8'd4,  32'h0000_6030, 5'd4},
    {4'hE, 8'd16, 32'h0000_7008, 5'd14},
    {4'hE, 8'd32, 32'h0000_8000, 5'd16}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {rsp_valid, dat_valid, ib_req, sts_discard, sts_ib_err, sts_pci_err}, 6'b0);
    rst_n = 1'b1;

    dr_bypass = 1'b1;
    do_req(32'h100, 4'hC, 5'd4);
    check("R12 bypass no response", {rsp_valid, ib_req}, 2'b00);
    dr_bypass = 1'b0;
    do_req(32'h100, 4'h7, 5'd4);
    check("R12 non-read ignored", {rsp_valid, ib_req}, 2'b00);

    foreach (VEC[v]) begin
      logic [3:0] c; logic [31:0] a; logic [4:0] l; logic [3:0] oc; logic [31:0] seed;
      c = VEC[v][48:45]; cls = VEC[v][44:37]; a = VEC[v][36:5]; l = VEC[v][4:0];
      oc = (c == 4'h6) ? 4'hE : 4'h6;
      seed = 32'hA000_0000 + 32'(v) * 32'h100;
      do_req(a, c, 5'd16);
      check("R2 first read retried", {rsp_valid, rsp_kind, ib_req, ib_addr}, {1'b1, 2'd0, 1'b1, a});
      check("R4 R5 R8 prefetch length", ib_len, l);
      feed(int'(l), seed);
      do_req(a, oc, 5'd16);
      check("R6 command mismatch retried", {rsp_valid, rsp_kind, dat_valid}, {1'b1, 2'd0, 1'b0});
      do_req(a, c, 5'd16);
      serve(int'(l), seed, (l < 5'd16) ? 2'd2 : 2'd1, "R6 R7 served burst");
    end

    cls = 8'd8;
    do_req(32'h200, 4'hC, 5'd0);
    feed(16, 32'hB000_0000);
    do_req(32'h204, 4'hC, 5'd3);
    check("R6 address mismatch retried", {rsp_valid, rsp_kind, dat_valid}, {1'b1, 2'd0, 1'b0});
    do_req(32'h200, 4'hC, 5'd3);
    serve(3, 32'hB000_0000, 2'd1, "R7 short request done");
    do_req(32'h300, 4'hE, 5'd0);
    feed(8, 32'hB100_0000);
    do_req(32'h300, 4'hE, 5'd0);
    serve(1, 32'hB100_0000, 2'd1, "R7 zero words counts as one");

    do_req(32'h9000, 4'hC, 5'd16);
    do_req(32'h9400, 4'h6, 5'd1);
    check("R3 retry during fetch", {rsp_valid, rsp_kind, ib_req}, {1'b1, 2'd0, 1'b0});
    feed(2, 32'hC000_0000);
    ib_err = 1'b1;
    @(negedge clk);
    ib_err = 1'b0;
    check("R10 both error flags", {sts_ib_err, sts_pci_err}, 2'b11);
    check("R11 both interrupts", {irq_int, irq_pci}, 2'b11);
    pci_mask = 1'b1; int_mask = 2'b10; #1;
    check("R11 masked", {irq_int, irq_pci}, 2'b00);
    pci_mask = 1'b0; int_mask = 2'b00;
    do_req(32'h9004, 4'hC, 5'd16);
    check("R10 mismatch after error retried", {rsp_valid, rsp_kind}, {1'b1, 2'd0});
    do_req(32'h9000, 4'hC, 5'd16);
    check("R10 target abort", {rsp_valid, rsp_kind, dat_valid}, {1'b1, 2'd3, 1'b0});
    flag_clr = 3'b110;
    @(negedge clk);
    flag_clr = 3'b000;
    check("R13 error flags cleared", {sts_ib_err, sts_pci_err, irq_pci}, 3'b000);

    do_req(32'hA000, 4'h6, 5'd1);
    check("R7 idle again after abort", {rsp_valid, rsp_kind, ib_req, ib_len}, {1'b1, 2'd0, 1'b1, 5'd1});
    feed(1, 32'hD000_0000);
    repeat (DISC - 1) @(negedge clk);
    check("R9 not dropped before limit", sts_discard, 1'b0);
    @(negedge clk);
    check("R9 dropped at limit", {sts_discard, irq_int}, 2'b11);
    int_mask = 2'b01; #1;
    check("R11 discard masked", irq_int, 1'b0);
    int_mask = 2'b00;
    do_req(32'hA000, 4'h6, 5'd1);
    check("R9 match after drop is new read", {rsp_valid, rsp_kind, ib_req, dat_valid}, {1'b1, 2'd0, 1'b1, 1'b0});
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = 3'b000;
    check("R13 discard cleared", {sts_discard, irq_int}, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule